// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block is the digital back end of a two-channel 14-bit sampling converter. Each channel delivers a raw signed conversion result together with an over-range and an under-range flag. A rate generator picks which clock cycles count as sampling strobes: every clock, every second clock or every fourth clock. On each strobe both channels capture their inputs.

Each captured sample passes through a fixed-latency pipeline. It leaves as either a two's-complement word or a Gray-coded word. The Gray code is taken from the offset-binary form of the sample. Every sample carries an out-of-range flag, which travels in lockstep with its data word.

A data-valid strobe marks each cycle in which the outputs hold a new, real sample. It stays quiet until the pipeline has refilled after reset or after power-down. Power-down releases every data, flag and valid output to high impedance, and a drive-enable output reports when the outputs are driven.

Top module: `adcf_dual_top`

## Requirements
- R1: With the format input low when a sample is captured, an in-range raw value leaves unchanged as a 14-bit two's-complement word.
- R2: With the format input high when a sample is captured, an in-range value leaves as Gray(raw XOR 0x2000), where Gray(x) = x XOR (x >> 1). Raw 0x0000 therefore gives 0x3000, and raw 0x3FFF (-1) gives 0x1000.
- R3: An over-range sample leaves as 0x1FFF in two's complement or 0x2000 in Gray. An under-range sample leaves as 0x2000 in two's complement or 0x0000 in Gray. When both flags are set, the over-range result wins.
- R4: A sample captured at strobe edge n appears on the outputs right after strobe edge n+8. Between strobes the outputs do not change.
- R5: Each channel's out-of-range output is the OR of the sample's two range flags. It has the same latency as its data word and updates together with it.
- R6: With the half-rate input high and the quarter-rate input low, a strobe occurs on every second clock.
- R7: With the quarter-rate input high, a strobe occurs on every fourth clock. This holds whatever the level of the half-rate input.
- R8: A change of the rate inputs restarts the divider. The clock edge that first sees the new setting makes no strobe, and the following edge does.
- R9: The data-valid output is high for exactly the cycle after each strobe edge that presents a real sample. It stays low for the first eight strobes after reset or after leaving power-down.
- R10: One clock edge after power-down is seen high, the drive-enable output is low and the data, flag and valid outputs are high impedance. No strobes occur while power-down is high.
- R11: The format input is sampled together with each sample. Changing it later does not alter samples already in the pipeline.
- R12: With both rate inputs low, a strobe occurs on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down request |
| gray_sel | input | 1 | Output format: 0 two's complement, 1 Gray |
| rate_half | input | 1 | Half-rate sampling select |
| rate_quarter | input | 1 | Quarter-rate sampling select (takes priority) |
| a_raw | input | 14 | Channel A raw signed result |
| a_ovr | input | 1 | Channel A over-range flag |
| a_und | input | 1 | Channel A under-range flag |
| b_raw | input | 14 | Channel B raw signed result |
| b_ovr | input | 1 | Channel B over-range flag |
| b_und | input | 1 | Channel B under-range flag |
| a_code | output | 14 | Channel A formatted word, high impedance when off |
| a_oor | output | 1 | Channel A out-of-range flag, high impedance when off |
| b_code | output | 14 | Channel B formatted word, high impedance when off |
| b_oor | output | 1 | Channel B out-of-range flag, high impedance when off |
| dvalid | output | 1 | New-sample strobe, high impedance when off |
| drive_en | output | 1 | High while the outputs are driven |

## Verification
The assertions assume that the rate inputs, the format input and the power-down input change only between clock edges and carry no unknown values once reset is released. They also assume that the raw words and range flags are defined whenever a strobe may capture them. The bench meets these assumptions by driving every input on the falling clock edge. It holds each table row for as many clocks as the selected rate divides by, so each row falls into exactly one strobe whatever the divider phase. Rate changes are always made to legal or priority-resolved pin settings.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

   typedef enum logic [1:0] {
      RATE_FULL    = 2'd0,
      RATE_HALF    = 2'd1,
      RATE_QUARTER = 2'd2
   } rate_e;

   // quarter select dominates, so both pins high resolves to quarter rate
   function automatic rate_e decode_rate(input logic half_i, input logic quarter_i);
      if (quarter_i)   return RATE_QUARTER;
      else if (half_i) return RATE_HALF;
      else             return RATE_FULL;
   endfunction

endpackage

// File: rtl/adcf_rate_gen.sv
module adcf_rate_gen
   import adcf_pkg::*;
#(
   parameter int unsigned HALF_DIV    = 2,
   parameter int unsigned QUARTER_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd,
   input  logic half_i,
   input  logic quarter_i,
   output logic tick
);
   localparam int unsigned CW = (QUARTER_DIV > 2) ? $clog2(QUARTER_DIV) : 1;

   if (HALF_DIV < 2) begin : g_bad_half
      $error("HALF_DIV must be at least 2");
   end
   if (QUARTER_DIV <= HALF_DIV) begin : g_bad_quarter
      $error("QUARTER_DIV must exceed HALF_DIV");
   end

   rate_e          want;
   rate_e          mode_q;
   logic [CW-1:0]  cnt;
   logic [CW-1:0]  last;

   always_comb begin
      want = decode_rate(half_i, quarter_i);
      case (mode_q)
         RATE_HALF:    last = CW'(HALF_DIV - 1);
         RATE_QUARTER: last = CW'(QUARTER_DIV - 1);
         default:      last = '0;
      endcase
   end

   assign tick = !pd && (want == mode_q) && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= RATE_FULL;
         cnt    <= '0;
      end else begin
         mode_q <= want;
         if (pd || (want != mode_q)) cnt <= '0;
         else if (cnt == last)       cnt <= '0;
         else                        cnt <= cnt + 1'b1;
      end
   end

   // R6: at half rate a strobe is never followed directly by another
   a_r6_half_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode_q == RATE_HALF) |=> !tick);

   if (QUARTER_DIV == 4) begin : g_quarter_chk
      // R7: at quarter rate three quiet clocks follow each strobe
      a_r7_quarter_gap: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && mode_q == RATE_QUARTER) |=> !tick ##1 !tick ##1 !tick);
   end

endmodule

// File: rtl/adcf_encode.sv
module adcf_encode #(
   parameter int unsigned W = 14
) (
   input  logic [W-1:0] raw,
   input  logic         ovr,
   input  logic         und,
   input  logic         gray,
   output logic [W-1:0] code,
   output logic         oor
);
   localparam logic [W-1:0] POS_FS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_FS = {1'b1, {(W-1){1'b0}}};

   if (W < 4) begin : g_bad_w
      $error("W must be at least 4");
   end

   logic [W-1:0] tc;
   logic [W-1:0] ob;

   always_comb begin
      if (ovr)      tc = POS_FS;
      else if (und) tc = NEG_FS;
      else          tc = raw;
      ob   = tc ^ NEG_FS;                 // offset binary: sign bit flipped
      code = gray ? (ob ^ (ob >> 1)) : tc;
      oor  = ovr | und;
   end

endmodule

// File: rtl/adcf_lane.sv
module adcf_lane #(
   parameter int unsigned W   = 14,
   parameter int unsigned LAT = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] raw,
   input  logic         ovr,
   input  logic         und,
   input  logic         gray,
   output logic [W-1:0] code_q,
   output logic         oor_q
);
   localparam logic [W-1:0] POS_FS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_FS = {1'b1, {(W-1){1'b0}}};

   if (LAT < 2) begin : g_bad_lat
      $error("LAT must be at least 2");
   end

   // entry register: raw sample with its format choice
   logic [W-1:0] e_raw;
   logic         e_ovr, e_und, e_gray;
   logic [W-1:0] enc_code;
   logic         enc_oor;
   logic [W-1:0] st_code [1:LAT];
   logic         st_oor  [1:LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_raw  <= '0;
         e_ovr  <= 1'b0;
         e_und  <= 1'b0;
         e_gray <= 1'b0;
      end else if (tick) begin
         e_raw  <= raw;
         e_ovr  <= ovr;
         e_und  <= und;
         e_gray <= gray;
      end
   end

   adcf_encode #(.W(W)) u_enc (
      .raw  (e_raw),
      .ovr  (e_ovr),
      .und  (e_und),
      .gray (e_gray),
      .code (enc_code),
      .oor  (enc_oor)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_code[1] <= '0;
         st_oor[1]  <= 1'b0;
      end else if (tick) begin
         st_code[1] <= enc_code;
         st_oor[1]  <= enc_oor;
      end
   end

   for (genvar k = 2; k <= LAT; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_code[k] <= '0;
            st_oor[k]  <= 1'b0;
         end else if (tick) begin
            st_code[k] <= st_code[k-1];
            st_oor[k]  <= st_oor[k-1];
         end
      end
   end

   assign code_q = st_code[LAT];
   assign oor_q  = st_oor[LAT];

   // R4: the pipeline outputs only move on a strobe
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(code_q) && $stable(oor_q)));

   // R3: a flagged word is always one of the saturation codes
   a_r3_sat_code: assert property (@(posedge clk) disable iff (!rst_n)
      oor_q |-> (code_q == POS_FS || code_q == NEG_FS || code_q == '0));

endmodule

// File: rtl/adcf_dual_top.sv
module adcf_dual_top #(
   parameter int unsigned W           = 14,
   parameter int unsigned LAT         = 8,
   parameter int unsigned HALF_DIV    = 2,
   parameter int unsigned QUARTER_DIV = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwr_dn,
   input  logic         gray_sel,
   input  logic         rate_half,
   input  logic         rate_quarter,
   input  logic [W-1:0] a_raw,
   input  logic         a_ovr,
   input  logic         a_und,
   input  logic [W-1:0] b_raw,
   input  logic         b_ovr,
   input  logic         b_und,
   output logic [W-1:0] a_code,
   output logic         a_oor,
   output logic [W-1:0] b_code,
   output logic         b_oor,
   output logic         dvalid,
   output logic         drive_en
);
   localparam int unsigned NCH = 2;
   localparam int unsigned FW  = $clog2(LAT + 2);

   logic         tick;
   logic [W-1:0] raw_v  [NCH];
   logic         ovr_v  [NCH];
   logic         und_v  [NCH];
   logic [W-1:0] code_v [NCH];
   logic         oor_v  [NCH];
   logic [FW-1:0] fill;
   logic         dv_q;
   logic         oe_q;

   assign raw_v[0] = a_raw;  assign ovr_v[0] = a_ovr;  assign und_v[0] = a_und;
   assign raw_v[1] = b_raw;  assign ovr_v[1] = b_ovr;  assign und_v[1] = b_und;

   adcf_rate_gen #(.HALF_DIV(HALF_DIV), .QUARTER_DIV(QUARTER_DIV)) u_rate (
      .clk       (clk),
      .rst_n     (rst_n),
      .pd        (pwr_dn),
      .half_i    (rate_half),
      .quarter_i (rate_quarter),
      .tick      (tick)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_lane
      adcf_lane #(.W(W), .LAT(LAT)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .raw    (raw_v[c]),
         .ovr    (ovr_v[c]),
         .und    (und_v[c]),
         .gray   (gray_sel),
         .code_q (code_v[c]),
         .oor_q  (oor_v[c])
      );
   end

   // fill counts strobes since restart; dv marks strobes that present real data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
         dv_q <= 1'b0;
         oe_q <= 1'b0;
      end else begin
         oe_q <= !pwr_dn;
         if (pwr_dn) begin
            fill <= '0;
            dv_q <= 1'b0;
         end else begin
            dv_q <= tick && (fill >= FW'(LAT));
            if (tick && (fill <= FW'(LAT))) fill <= fill + 1'b1;
         end
      end
   end

   assign drive_en = oe_q;
   assign a_code   = oe_q ? code_v[0] : {W{1'bz}};
   assign b_code   = oe_q ? code_v[1] : {W{1'bz}};
   assign a_oor    = oe_q ? oor_v[0]  : 1'bz;
   assign b_oor    = oe_q ? oor_v[1]  : 1'bz;
   assign dvalid   = oe_q ? dv_q      : 1'bz;

   // R10: nothing is flagged valid while the outputs are released
   a_r10_silent_off: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_q |-> !dv_q);

   // R9: a valid strobe only after the pipeline has completely refilled
   a_r9_filled: assert property (@(posedge clk) disable iff (!rst_n)
      dv_q |-> (fill == FW'(LAT + 1)));

endmodule

// File: tb/tb_adcf_dual_top.sv
module tb_adcf_dual_top;

   typedef struct packed {
      logic        sel;
      logic        ao, au;
      logic [13:0] araw, aexp;
      logic        aoor;
      logic        bo, bu;
      logic [13:0] braw, bexp;
      logic        boor;
   } vec_t;

   localparam int NV = 14;
   // expected words worked out from R1, R2, R3 and R5
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b0,1'b0, 14'h0000,14'h0000,1'b0, 1'b0,1'b0, 14'h0F0F,14'h0F0F,1'b0},
      '{1'b0, 1'b0,1'b0, 14'h1234,14'h1234,1'b0, 1'b0,1'b1, 14'h0000,14'h2000,1'b1},
      '{1'b0, 1'b0,1'b0, 14'h3FFF,14'h3FFF,1'b0, 1'b1,1'b0, 14'h0000,14'h1FFF,1'b1},
      '{1'b0, 1'b1,1'b0, 14'h0000,14'h1FFF,1'b1, 1'b0,1'b0, 14'h2ABC,14'h2ABC,1'b0},
      '{1'b0, 1'b0,1'b1, 14'h0000,14'h2000,1'b1, 1'b0,1'b0, 14'h0001,14'h0001,1'b0},
      '{1'b1, 1'b0,1'b0, 14'h0000,14'h3000,1'b0, 1'b0,1'b0, 14'h0001,14'h3001,1'b0},
      '{1'b1, 1'b1,1'b0, 14'h0000,14'h2000,1'b1, 1'b0,1'b0, 14'h3FFF,14'h1000,1'b0},
      '{1'b1, 1'b0,1'b1, 14'h0000,14'h0000,1'b1, 1'b1,1'b0, 14'h0000,14'h2000,1'b1},
      '{1'b1, 1'b0,1'b0, 14'h3FFF,14'h1000,1'b0, 1'b0,1'b1, 14'h0000,14'h0000,1'b1},
      '{1'b1, 1'b0,1'b0, 14'h0001,14'h3001,1'b0, 1'b0,1'b0, 14'h0000,14'h3000,1'b0},
      '{1'b0, 1'b1,1'b1, 14'h0555,14'h1FFF,1'b1, 1'b0,1'b0, 14'h1FFF,14'h1FFF,1'b0},
      '{1'b0, 1'b0,1'b0, 14'h2000,14'h2000,1'b0, 1'b1,1'b1, 14'h0000,14'h1FFF,1'b1},
      '{1'b1, 1'b0,1'b0, 14'h0003,14'h3002,1'b0, 1'b0,1'b0, 14'h1FFF,14'h2000,1'b0},
      '{1'b1, 1'b0,1'b0, 14'h1FFF,14'h2000,1'b0, 1'b1,1'b1, 14'h1234,14'h2000,1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_dn = 1'b0, gray_sel = 1'b0, rate_half = 1'b0, rate_quarter = 1'b0;
   logic [13:0] a_raw = '0, b_raw = '0;
   logic        a_ovr = 1'b0, a_und = 1'b0, b_ovr = 1'b0, b_und = 1'b0;
   logic [13:0] a_code, b_code;
   logic        a_oor, b_oor, dvalid, drive_en;

   int checks = 0;
   int errors = 0;
   bit mon_on = 1'b0;
   int mon_idx = 0;
   string mon_tag = "";

   always #2.5 clk = ~clk;

   adcf_dual_top dut (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .gray_sel(gray_sel),
      .rate_half(rate_half), .rate_quarter(rate_quarter),
      .a_raw(a_raw), .a_ovr(a_ovr), .a_und(a_und),
      .b_raw(b_raw), .b_ovr(b_ovr), .b_und(b_und),
      .a_code(a_code), .a_oor(a_oor), .b_code(b_code), .b_oor(b_oor),
      .dvalid(dvalid), .drive_en(drive_en)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
      end
   endtask

   task automatic drive_row(input int i);
      gray_sel = VEC[i].sel;
      a_raw = VEC[i].araw; a_ovr = VEC[i].ao; a_und = VEC[i].au;
      b_raw = VEC[i].braw; b_ovr = VEC[i].bo; b_und = VEC[i].bu;
   endtask

   task automatic do_reset(input logic h, input logic q);
      @(negedge clk);
      rst_n = 1'b0; pwr_dn = 1'b0; rate_half = h; rate_quarter = q;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // scoreboard: every valid strobe must show the next table row (R1 R2 R3 R5 R11)
   always @(negedge clk) begin
      if (mon_on && dvalid === 1'b1 && mon_idx < NV) begin
         chk(a_code === VEC[mon_idx].aexp && a_oor === VEC[mon_idx].aoor,
             {mon_tag, " R1/R2/R3/R5/R11 chan A"}, {a_oor, a_code},
             {VEC[mon_idx].aoor, VEC[mon_idx].aexp});
         chk(b_code === VEC[mon_idx].bexp && b_oor === VEC[mon_idx].boor,
             {mon_tag, " R1/R2/R3/R5/R11 chan B"}, {b_oor, b_code},
             {VEC[mon_idx].boor, VEC[mon_idx].bexp});
         mon_idx++;
      end
   end

   task automatic run_table(input logic h, input logic q, input int div, input string tag);
      do_reset(h, q);
      mon_tag = tag; mon_idx = 0; mon_on = 1'b1;
      for (int i = 0; i < NV; i++) begin
         drive_row(i);
         repeat (div) @(negedge clk);
      end
      repeat (10 * div) @(negedge clk);
      mon_on = 1'b0;
      chk(mon_idx == NV, {tag, " all rows delivered (R6 R7 R12)"}, mon_idx, NV);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // reset state
      @(negedge clk);
      chk(drive_en === 1'b0, "reset drive_en low R10", drive_en, 0);
      do_reset(1'b0, 1'b0);
      @(negedge clk);
      chk(drive_en === 1'b1, "drive_en after reset R10", drive_en, 1);
      chk(dvalid === 1'b0, "dvalid low before fill R9", dvalid, 0);

      // table walk at each rate
      run_table(1'b0, 1'b0, 1, "full R12");
      run_table(1'b1, 1'b0, 2, "half R6");
      run_table(1'b1, 1'b1, 4, "quarter-both-pins R7");

      // latency at full rate: sample at edge 1 shows after edge 9 (R4, R9)
      gray_sel = 1'b0; a_ovr = 1'b0; a_und = 1'b0;
      a_raw = 14'd16;
      do_reset(1'b0, 1'b0);
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         a_raw = 14'(16 * (k + 1));
         if (k == 8) chk(dvalid === 1'b0, "dvalid before 8 strobes R9", dvalid, 0);
         if (k == 9) begin
            chk(dvalid === 1'b1, "dvalid after 8 strobes R9", dvalid, 1);
            chk(a_code === 14'd16, "latency first word R4", a_code, 16);
         end
         if (k == 10) chk(a_code === 14'd32, "latency second word R4", a_code, 32);
      end

      // power-down and recovery (R10, R9)
      pwr_dn = 1'b1;
      @(negedge clk);
      chk(drive_en === 1'b0, "drive_en off in power-down R10", drive_en, 0);
      repeat (3) @(negedge clk);
      chk(drive_en === 1'b0, "drive_en stays off R10", drive_en, 0);
      a_raw = 14'h0777;
      pwr_dn = 1'b0;
      for (int k = 1; k <= 9; k++) begin
         @(negedge clk);
         a_raw = 14'h0100;
         if (k == 1) chk(drive_en === 1'b1, "drive_en back on R10", drive_en, 1);
         if (k == 8) chk(dvalid === 1'b0, "refill after power-down R9", dvalid, 0);
         if (k == 9) begin
            chk(dvalid === 1'b1, "valid after refill R9", dvalid, 1);
            chk(a_code === 14'h0777, "first word after power-down R4", a_code, 14'h0777);
         end
      end

      // rate change restarts divider (R8): half -> quarter
      rate_half = 1'b1; rate_quarter = 1'b0;
      repeat (6) @(negedge clk);
      rate_half = 1'b0; rate_quarter = 1'b1;
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         if (k == 1) chk(dvalid === 1'b0, "no strobe on change edge R8", dvalid, 0);
         if (k == 2) chk(dvalid === 1'b1, "strobe right after change R8", dvalid, 1);
         if (k == 3) chk(dvalid === 1'b0, "quarter gap R7", dvalid, 0);
         if (k == 5) chk(dvalid === 1'b0, "quarter gap end R7", dvalid, 0);
         if (k == 6) chk(dvalid === 1'b1, "quarter next strobe R7", dvalid, 1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule